// File: doc/BRIEF.md
# SHA-2 Sigma and Sum Functional Unit

This unit evaluates the SHA-2 message-schedule functions (small sigma) and round-compression functions (big sum) for one instruction per accepted request. The SHA-256 functions work on the low 32 bits of one register operand. On a 32-bit datapath, the SHA-512 functions are split into half-operations. Two 32-bit source operands are joined into one 64-bit word, and each half-operation returns one 32-bit half of the 64-bit function result. Software issues two half-operations and puts the halves together to get the full 64-bit value.

Each request is accepted with a valid/ready handshake on the input side. After acceptance, the result is registered and offered one cycle later with its own valid/ready pair. A code that is unknown, or not allowed at the configured register width, does not change the held result. Instead it raises an illegal-instruction flag. The register width `XLEN` is 32 or 64. At 64 bits, the SHA-256 results are sign-extended and all SHA-512 half-operations are illegal. The upstream reset source must deassert `rst_n` in step with `clk`.

Top module: `sha2_sigma_unit`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `out_illegal` are 0, `out_result` is 0 and `in_ready` is 1.
- R2: Code 0 returns ror(x,7)^ror(x,18)^(x>>3) and code 1 returns ror(x,17)^ror(x,19)^(x>>10), where x is the low 32 bits of `in_rs1`.
- R3: Code 2 returns ror(x,2)^ror(x,13)^ror(x,22) and code 3 returns ror(x,6)^ror(x,11)^ror(x,25), on the same 32-bit x.
- R4: Codes 0 to 3 ignore every bit of `in_rs1` above bit 31 and all of `in_rs2`. When XLEN is 64, bits 63:32 of the result copy bit 31.
- R5: Let w = {in_rs2[31:0], in_rs1[31:0]}. Code 4 returns the low half of rol(w,25)^rol(w,30)^ror(w,28), and code 5 returns the low half of rol(w,23)^ror(w,14)^ror(w,18). Issuing each code once with the operands in order and once with them swapped gives the low and high halves of the 64-bit big sum functions.
- R6: Code 6 returns the low half of ror(w,1)^ror(w,7)^ror(w,8), and code 8 returns the low half of rol(w,3)^ror(w,6)^ror(w,19). These are the low halves of the 64-bit small sigma0 and sigma1.
- R7: Code 7 returns the low half of ror(w,1)^({32'b0,w[31:0]}>>7)^ror(w,8), and code 9 returns the low half of rol(w,3)^({32'b0,w[31:0]}>>6)^ror(w,19). With the high source word in `in_rs1`, these give the high halves of the 64-bit small sigma0 and sigma1.
- R8: Codes 10 to 15 are illegal at any width, and codes 4 to 9 are illegal when XLEN is 64. An accepted illegal code sets `out_illegal` to 1 and leaves `out_result` unchanged. An accepted legal code clears `out_illegal`.
- R9: A request accepted at a clock edge makes `out_valid` 1 after that edge. With `out_ready` high and no new request, `out_valid` falls at the next edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. In that state `out_valid`, `out_result` and `out_illegal` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 4 | Function code |
| in_rs1 | input | XLEN | First source operand (low word for SHA-512 halves) |
| in_rs2 | input | XLEN | Second source operand (high word for SHA-512 halves) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Registered function result |
| out_illegal | output | 1 | Last accepted code was illegal |

## Verification
The properties assume that `in_op` holds a known value whenever `in_valid` is high. They also assume that reset is released on a clock boundary, so that the hold and handshake relations are defined from the first active cycle. The bench changes every input only on the falling edge. It holds `in_valid` for exactly one accepting cycle, and it stalls only by lowering `out_ready`. A 32-bit and a 64-bit instance share the same stimulus. Operand pairs include all-zero, all-one and single-bit words, and for every operand pair each of the sixteen codes is applied.

// File: rtl/sha2_sigma_pkg.sv
package sha2_sigma_pkg;

  localparam int unsigned OP_W   = 4;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned FULL_W = 2 * HALF_W;

  typedef enum logic [OP_W-1:0] {
    OP_S256_SIG0  = 4'd0,
    OP_S256_SIG1  = 4'd1,
    OP_S256_SUM0  = 4'd2,
    OP_S256_SUM1  = 4'd3,
    OP_S512_SUM0R = 4'd4,
    OP_S512_SUM1R = 4'd5,
    OP_S512_SIG0L = 4'd6,
    OP_S512_SIG0H = 4'd7,
    OP_S512_SIG1L = 4'd8,
    OP_S512_SIG1H = 4'd9
  } sigma_op_e;

  typedef struct packed {
    logic legal;
    logic wide;
  } op_class_t;

  function automatic logic [HALF_W-1:0] ror32(input logic [HALF_W-1:0] x,
                                              input int unsigned n);
    return (x >> n) | (x << (HALF_W - n));
  endfunction

  function automatic logic [FULL_W-1:0] ror64(input logic [FULL_W-1:0] x,
                                              input int unsigned n);
    return (x >> n) | (x << (FULL_W - n));
  endfunction

  function automatic logic [FULL_W-1:0] rol64(input logic [FULL_W-1:0] x,
                                              input int unsigned n);
    return (x << n) | (x >> (FULL_W - n));
  endfunction

endpackage

// File: rtl/sha2_op_decode.sv
module sha2_op_decode
  import sha2_sigma_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OP_W-1:0] op,
  output op_class_t       cls
);

  localparam bit HALVES_OK = (XLEN == HALF_W);

  always_comb begin
    cls.legal = 1'b0;
    cls.wide  = 1'b0;
    case (op)
      OP_S256_SIG0, OP_S256_SIG1, OP_S256_SUM0, OP_S256_SUM1: begin
        cls.legal = 1'b1;
      end
      OP_S512_SUM0R, OP_S512_SUM1R, OP_S512_SIG0L,
      OP_S512_SIG0H, OP_S512_SIG1L, OP_S512_SIG1H: begin
        cls.wide  = 1'b1;
        cls.legal = HALVES_OK;
      end
      default: begin
        cls.legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sha256_sigma_core.sv
module sha256_sigma_core
  import sha2_sigma_pkg::*;
(
  input  logic [1:0]        fsel,
  input  logic [HALF_W-1:0] x,
  output logic [HALF_W-1:0] y
);

  logic [HALF_W-1:0] small0, small1, big0, big1;

  always_comb begin
    small0 = ror32(x, 7)  ^ ror32(x, 18) ^ (x >> 3);
    small1 = ror32(x, 17) ^ ror32(x, 19) ^ (x >> 10);
    big0   = ror32(x, 2)  ^ ror32(x, 13) ^ ror32(x, 22);
    big1   = ror32(x, 6)  ^ ror32(x, 11) ^ ror32(x, 25);
  end

  always_comb begin
    case (fsel)
      2'd0:    y = small0;
      2'd1:    y = small1;
      2'd2:    y = big0;
      default: y = big1;
    endcase
  end

endmodule

// File: rtl/sha512_half_core.sv
module sha512_half_core
  import sha2_sigma_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [HALF_W-1:0] lo_word,
  input  logic [HALF_W-1:0] hi_word,
  output logic [HALF_W-1:0] y
);

  logic [FULL_W-1:0] w;
  logic [FULL_W-1:0] w_lo_zx;
  logic [FULL_W-1:0] t_sum0, t_sum1, t_sig0l, t_sig0h, t_sig1l, t_sig1h;

  assign w       = {hi_word, lo_word};
  assign w_lo_zx = {{HALF_W{1'b0}}, lo_word};

  always_comb begin
    t_sum0  = rol64(w, 25) ^ rol64(w, 30) ^ ror64(w, 28);
    t_sum1  = rol64(w, 23) ^ ror64(w, 14) ^ ror64(w, 18);
    t_sig0l = ror64(w, 1)  ^ ror64(w, 7)  ^ ror64(w, 8);
    t_sig0h = ror64(w, 1)  ^ (w_lo_zx >> 7) ^ ror64(w, 8);
    t_sig1l = rol64(w, 3)  ^ ror64(w, 6)  ^ ror64(w, 19);
    t_sig1h = rol64(w, 3)  ^ (w_lo_zx >> 6) ^ ror64(w, 19);
  end

  always_comb begin
    case (op)
      OP_S512_SUM0R: y = t_sum0[HALF_W-1:0];
      OP_S512_SUM1R: y = t_sum1[HALF_W-1:0];
      OP_S512_SIG0L: y = t_sig0l[HALF_W-1:0];
      OP_S512_SIG0H: y = t_sig0h[HALF_W-1:0];
      OP_S512_SIG1L: y = t_sig1l[HALF_W-1:0];
      OP_S512_SIG1H: y = t_sig1h[HALF_W-1:0];
      default:       y = '0;
    endcase
  end

endmodule

// File: rtl/sha2_sigma_unit.sv
module sha2_sigma_unit
  import sha2_sigma_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);

  localparam int unsigned EXT_W = XLEN - HALF_W;

  op_class_t          cls;
  logic [HALF_W-1:0]  res_256;
  logic [HALF_W-1:0]  res_512;
  logic [HALF_W-1:0]  res_narrow;
  logic [XLEN-1:0]    res_full;

  logic               accept;
  logic               vld_q, vld_d, vld_en;
  logic               ill_q, ill_d, ill_en;
  logic [XLEN-1:0]    res_q, res_d;
  logic               res_en;

  sha2_op_decode #(.XLEN(XLEN)) u_decode (
    .op  (in_op),
    .cls (cls)
  );

  sha256_sigma_core u_core256 (
    .fsel (in_op[1:0]),
    .x    (in_rs1[HALF_W-1:0]),
    .y    (res_256)
  );

  if (XLEN == HALF_W) begin : g_halves
    sha512_half_core u_core512 (
      .op      (in_op),
      .lo_word (in_rs1[HALF_W-1:0]),
      .hi_word (in_rs2[HALF_W-1:0]),
      .y       (res_512)
    );
  end else begin : g_no_halves
    assign res_512 = '0;
  end

  assign res_narrow = cls.wide ? res_512 : res_256;

  if (XLEN > HALF_W) begin : g_sext
    assign res_full = {{EXT_W{res_narrow[HALF_W-1]}}, res_narrow};
  end else begin : g_plain
    assign res_full = res_narrow;
  end

  // handshake and next-state
  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    vld_en = accept || out_ready;
    vld_d  = accept;
    ill_en = accept;
    ill_d  = !cls.legal;
    res_en = accept && cls.legal;
    res_d  = res_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      res_q <= '0;
    end else begin
      if (vld_en) vld_q <= vld_d;
      if (ill_en) ill_q <= ill_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_illegal = ill_q;
  assign out_result  = res_q;

endmodule

// File: rtl/sha2_sigma_unit_chk.sv
module sha2_sigma_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [3:0]      in_op,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);

  assert_accept_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_stall_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  assert_bad_code_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op >= 4'd10) |=> (out_illegal && $stable(out_result)));

  assert_good_code_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op < 4'd4) |=> !out_illegal);

  if (XLEN > 32) begin : g_sext_chk
    assert_sign_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}}));
  end

endmodule

bind sha2_sigma_unit sha2_sigma_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/test_sha2_sigma_unit.sv
module test_sha2_sigma_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [63:0] rs1_w, rs2_w;
  logic        out_ready;

  logic        rdy32, vld32, ill32;
  logic [31:0] res32;
  logic        rdy64, vld64, ill64;
  logic [63:0] res64;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] p32;
  logic [63:0] p64;
  logic [31:0] seed = 32'h1234_5678;

  sha2_sigma_unit #(.XLEN(32)) i_sha2_sigma_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy32),
    .in_op(in_op), .in_rs1(rs1_w[31:0]), .in_rs2(rs2_w[31:0]),
    .out_valid(vld32), .out_ready(out_ready), .out_result(res32),
    .out_illegal(ill32)
  );

  sha2_sigma_unit #(.XLEN(64)) i_sha2_sigma_unit_x64 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy64),
    .in_op(in_op), .in_rs1(rs1_w), .in_rs2(rs2_w),
    .out_valid(vld64), .out_ready(out_ready), .out_result(res64),
    .out_illegal(ill64)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] r32(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [63:0] r64(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [31:0] f256(input logic [1:0] k, input logic [31:0] x);
    case (k)
      2'd0:    return r32(x, 7)  ^ r32(x, 18) ^ (x >> 3);
      2'd1:    return r32(x, 17) ^ r32(x, 19) ^ (x >> 10);
      2'd2:    return r32(x, 2)  ^ r32(x, 13) ^ r32(x, 22);
      default: return r32(x, 6)  ^ r32(x, 11) ^ r32(x, 25);
    endcase
  endfunction

  // full 64-bit SHA-512 functions
  function automatic logic [63:0] big0(input logic [63:0] x);
    return r64(x, 28) ^ r64(x, 34) ^ r64(x, 39);
  endfunction
  function automatic logic [63:0] big1(input logic [63:0] x);
    return r64(x, 14) ^ r64(x, 18) ^ r64(x, 41);
  endfunction
  function automatic logic [63:0] sml0(input logic [63:0] x);
    return r64(x, 1) ^ r64(x, 8) ^ (x >> 7);
  endfunction
  function automatic logic [63:0] sml1(input logic [63:0] x);
    return r64(x, 19) ^ r64(x, 61) ^ (x >> 6);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_word();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    p32      = res32;
    p64      = res64;
    in_valid = 1'b1;
    in_op    = op;
    rs1_w    = {a ^ 32'hc3a5_0f96, a};
    rs2_w    = {~b, b};
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 valid after accept", {63'd0, vld32}, 64'd1);
    chk("R9 valid after accept x64", {63'd0, vld64}, 64'd1);
    if (op >= 4'd10) begin
      chk("R8 flag", {63'd0, ill32}, 64'd1);
      chk("R8 result kept", {32'd0, res32}, {32'd0, p32});
      chk("R8 flag x64", {63'd0, ill64}, 64'd1);
      chk("R8 result kept x64", res64, p64);
    end else if (op >= 4'd4) begin
      chk("R8 legal at 32", {63'd0, ill32}, 64'd0);
      chk("R8 half illegal x64", {63'd0, ill64}, 64'd1);
      chk("R8 result kept x64", res64, p64);
    end else begin
      chk("R8 legal", {63'd0, ill32}, 64'd0);
      chk("R8 legal x64", {63'd0, ill64}, 64'd0);
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<50000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] a, b, lo, hi, e, keep;
    in_valid  = 1'b0;
    in_op     = 4'd0;
    rs1_w     = '0;
    rs2_w     = '0;
    out_ready = 1'b1;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 valid", {63'd0, vld32}, 64'd0);
    chk("R1 illegal", {63'd0, ill32}, 64'd0);
    chk("R1 result", {32'd0, res32}, 64'd0);
    chk("R1 ready", {63'd0, rdy32}, 64'd1);
    chk("R1 result x64", res64, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", {63'd0, vld64}, 64'd0);

    for (int i = 0; i < 40; i++) begin
      case (i)
        0:       begin a = 32'h0000_0000; b = 32'h0000_0000; end
        1:       begin a = 32'hffff_ffff; b = 32'hffff_ffff; end
        2:       begin a = 32'h8000_0000; b = 32'h0000_0001; end
        3:       begin a = 32'h0000_0001; b = 32'h8000_0000; end
        4:       begin a = 32'hffff_ffff; b = 32'h0000_0000; end
        default: begin a = next_word(); b = next_word(); end
      endcase

      // SHA-256 functions (R2, R3, R4)
      for (int k = 0; k < 4; k++) begin
        issue(k[3:0], a, b);
        e = f256(k[1:0], a);
        if (k < 2) chk("R2 small sigma", {32'd0, res32}, {32'd0, e});
        else       chk("R3 big sum", {32'd0, res32}, {32'd0, e});
        chk("R4 upper ignored, sign copy x64", res64, {{32{e[31]}}, e});
      end

      // R5 big sums by halves
      issue(4'd4, a, b); lo = res32;
      issue(4'd4, b, a); hi = res32;
      chk("R5 sum0 recombined", {hi, lo}, big0({b, a}));
      issue(4'd5, a, b); lo = res32;
      issue(4'd5, b, a); hi = res32;
      chk("R5 sum1 recombined", {hi, lo}, big1({b, a}));

      // R6 low, R7 high halves of small sigmas
      issue(4'd6, a, b); lo = res32;
      issue(4'd7, b, a); hi = res32;
      chk("R6 sig0 low", {32'd0, lo}, {32'd0, sml0({b, a})[31:0]});
      chk("R7 sig0 high", {32'd0, hi}, {32'd0, sml0({b, a})[63:32]});
      issue(4'd8, a, b); lo = res32;
      issue(4'd9, b, a); hi = res32;
      chk("R6 sig1 low", {32'd0, lo}, {32'd0, sml1({b, a})[31:0]});
      chk("R7 sig1 high", {32'd0, hi}, {32'd0, sml1({b, a})[63:32]});

      // R8 unlisted codes
      for (int k = 10; k < 16; k++) issue(k[3:0], a, b);
      issue(4'd0, b, a);
      chk("R8 legal clears flag", {63'd0, ill32}, 64'd0);
    end

    // R9 drain: no new request, out_ready high
    @(negedge clk);
    chk("R9 valid falls", {63'd0, vld32}, 64'd0);
    chk("R9 valid falls x64", {63'd0, vld64}, 64'd0);

    // R10 back-pressure
    out_ready = 1'b0;
    issue(4'd2, 32'hdead_beef, 32'h0);
    keep = res32;
    chk("R10 ready low when stalled", {63'd0, rdy32}, 64'd0);
    in_valid = 1'b1;
    in_op    = 4'd11;
    rs1_w    = 64'h0123_4567_89ab_cdef;
    @(posedge clk);
    @(negedge clk);
    chk("R10 valid held", {63'd0, vld32}, 64'd1);
    chk("R10 result held", {32'd0, res32}, {32'd0, keep});
    chk("R10 flag held", {63'd0, ill32}, 64'd0);
    chk("R10 ready still low", {63'd0, rdy32}, 64'd0);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 drained", {63'd0, vld32}, 64'd0);
    chk("R10 ready again", {63'd0, rdy32}, 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule